// File: doc/BRIEF.md
# Serial flash erase command engine

This block is the command side of a serial NOR flash slave. It samples chip select, serial clock and serial data in the system clock domain. It decodes six one-byte commands: write enable, read status, read lock byte, page erase, subsector erase and sector erase. It holds the write-enable latch (WEL) and the write-in-progress flag (WIP). A down-counter stands in for the self-timed erase, and when that count ends the block pulses a strobe that gives an external behavioural array the base address and size of the region to clear.

Before an erase is accepted, five conditions must hold: chip select rises exactly after the 32nd latched bit, WEL is set, no cycle is running, the region is not protected, and the reset pin is released. Protection comes from two input vectors. One holds two bits per 64 KB sector (write-lock and lock-down). The other holds one hardware-protect bit per 4 KB subsector. Pulling the reset pin low aborts a running erase and blocks new transactions for a recovery window.

The serial inputs must be synchronous to `clk`, and each serial clock level must last at least two `clk` cycles. Regions are 256-byte pages, 4 KB subsectors and 64 KB sectors. Address bits at or above `ADDR_W` are ignored.

Top module: `fl_erase_engine`

## Requirements
- R1: Command 0x06 sets WEL once its 8th bit is latched, unless a cycle is running. Command 0x05 returns the status byte on `so`: bit 0 is WIP and bit 1 is WEL, shifted MSB first with one bit after each falling serial clock edge. The byte repeats for as long as clocking continues.
- R2: An erase (0xDB page, 0x20 subsector, 0xD8 sector) runs only if chip select rises when exactly 32 bits have been latched. Deselecting after any other count discards the erase and leaves WEL unchanged.
- R3: An erase with WEL clear does nothing.
- R4: An accepted erase keeps WIP at 1 for T_PE, T_SSE or T_SE clock cycles, depending on its kind. `erase_stb` then pulses for one cycle. Counting from the first rising clock edge that samples chip select high, the pulse begins at edge T+2. It carries `erase_size` (0 page, 1 subsector, 2 sector). WIP reads 0 afterwards.
- R5: WEL is cleared in the cycle in which the erase starts, and reads 0 while the cycle runs and after it ends.
- R6: While a cycle runs, the commands 0x06, 0xE8 and all erases are ignored, and the running cycle keeps its duration, region and single strobe.
- R7: A page or subsector erase is refused if the sector's write-lock bit (`sect_lock[2s]`) or the subsector's bit in `sub_hwp` is set. A sector erase is refused if the write-lock bit or any of its 16 subsector bits is set. A refused erase leaves WEL at 1.
- R8: Any address inside a region selects that region. `erase_base` is the address with the offset inside the region cleared.
- R9: After 0xE8 and 24 address bits, `so` shifts the byte {6'b0, `sect_lock[2s+1]`, `sect_lock[2s]`} for the addressed sector s, MSB first, one bit per falling edge, repeating.
- R10: While `rst_pin_n` is low, a running erase is aborted with no strobe, and WIP and WEL are cleared. Any transaction that begins within T_RCV cycles after release is ignored until chip select next rises.
- R11: An unknown command code changes no state and leaves `so` at 0 until deselect.
- R12: After synchronous reset, WEL, WIP, `so` and `erase_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, sampled |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| rst_pin_n | input | 1 | Device reset pin, active low |
| sect_lock | input | 2*NSEC | Per sector: bit 2s write-lock, bit 2s+1 lock-down |
| sub_hwp | input | NSUB | Per subsector hardware protect |
| erase_stb | output | 1 | One-cycle erase strobe at end of cycle |
| erase_base | output | ADDR_W | Aligned base address of erased region |
| erase_size | output | 2 | 0 page, 1 subsector, 2 sector |

## Verification
The bound assertions check the properties that hold on every cycle. An erase can start only from a set WEL, and WEL reads clear in the start cycle. A start follows a chip-select rise. The strobe comes only at the end of a busy span, with a legal size and an aligned base. Busy ends only by completion or by the reset pin. Other behaviour depends on the sequence of commands and only the bench scenarios can show it. That covers exact durations per erase kind, deselect at the wrong bit count, protection outcomes, readout of the lock byte and status byte, commands ignored during a cycle, and the recovery lockout after the reset pin. The bench sweeps every erase kind over every sector, every lock value over every sector, and several deselect points.

// File: rtl/fl_erase_pkg.sv
package fl_erase_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_RDLK = 8'hE8;
  localparam logic [7:0] OP_PGER = 8'hDB;
  localparam logic [7:0] OP_SSER = 8'h20;
  localparam logic [7:0] OP_SCER = 8'hD8;

  typedef enum logic [1:0] {
    ER_PAGE = 2'd0,
    ER_SUB  = 2'd1,
    ER_SECT = 2'd2,
    ER_NONE = 2'd3
  } er_kind_t;

  function automatic er_kind_t kind_of(input logic [7:0] op);
    case (op)
      OP_PGER: kind_of = ER_PAGE;
      OP_SSER: kind_of = ER_SUB;
      OP_SCER: kind_of = ER_SECT;
      default: kind_of = ER_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fl_serial_rx.sv
module fl_serial_rx #(
  parameter int CNT_W = 6,
  parameter int SH_W  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             block,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             si,
  output logic             act,
  output logic [CNT_W-1:0] cnt,
  output logic [SH_W-1:0]  sh,
  output logic             bit_stb,
  output logic             fall_stb,
  output logic             end_stb,
  output logic             start_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sck_q, cs_q;
  logic sck_rise, sck_fall, cs_fall;

  assign sck_rise = sck && !sck_q;
  assign sck_fall = !sck && sck_q;
  assign cs_fall  = !cs_n && cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      act       <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      bit_stb   <= 1'b0;
      fall_stb  <= 1'b0;
      end_stb   <= 1'b0;
      start_stb <= 1'b0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      bit_stb   <= 1'b0;
      fall_stb  <= 1'b0;
      end_stb   <= 1'b0;
      start_stb <= 1'b0;
      if (block) begin
        act <= 1'b0;
      end else if (cs_fall) begin
        act       <= 1'b1;
        cnt       <= '0;
        start_stb <= 1'b1;
      end else if (act) begin
        if (cs_n) begin
          act     <= 1'b0;
          end_stb <= 1'b1;
        end else if (sck_rise) begin
          sh      <= {sh[SH_W-2:0], si};
          bit_stb <= 1'b1;
          if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        end else if (sck_fall) begin
          fall_stb <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fl_region_guard.sv
module fl_region_guard
  import fl_erase_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int SEC_W = ADDR_W - 16,
  localparam int SUB_W = ADDR_W - 12,
  localparam int NSEC  = 1 << SEC_W,
  localparam int NSUB  = 1 << SUB_W
) (
  input  logic [SUB_W-1:0]  sub_idx,
  input  er_kind_t          kind,
  input  logic [2*NSEC-1:0] sect_lock,
  input  logic [NSUB-1:0]   sub_hwp,
  output logic              ok
);
  logic [SEC_W-1:0] sec;
  logic wr_lock, hw_here, hw_any;

  assign sec     = sub_idx[SUB_W-1:4];
  assign wr_lock = sect_lock[{sec, 1'b0}];
  assign hw_here = sub_hwp[sub_idx];
  assign hw_any  = |sub_hwp[{sec, 4'b0000} +: 16];

  always_comb begin
    case (kind)
      ER_PAGE, ER_SUB: ok = !wr_lock && !hw_here;
      ER_SECT:         ok = !wr_lock && !hw_any;
      default:         ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fl_erase_timer.sv
module fl_erase_timer #(
  parameter int TM_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            start,
  input  logic [TM_W-1:0] dur,
  output logic            busy,
  output logic            done
);
  logic [TM_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      left <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
      left <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      left <= dur - TM_W'(1);
    end else if (busy) begin
      if (left == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        left <= left - TM_W'(1);
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/fl_erase_engine.sv
module fl_erase_engine
  import fl_erase_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int TM_W   = 20,
  parameter int T_PE   = 2000,
  parameter int T_SSE  = 8000,
  parameter int T_SE   = 40000,
  parameter int T_RCV  = 64,
  localparam int NSEC  = 1 << (ADDR_W - 16),
  localparam int NSUB  = 1 << (ADDR_W - 12)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  input  logic              rst_pin_n,
  input  logic [2*NSEC-1:0] sect_lock,
  input  logic [NSUB-1:0]   sub_hwp,
  output logic              erase_stb,
  output logic [ADDR_W-1:0] erase_base,
  output logic [1:0]        erase_size
);
  localparam int SH_W = 24;

  logic             rx_act, rx_bit, rx_fall, rx_end, rx_start;
  logic [5:0]       rx_cnt;
  logic [SH_W-1:0]  rx_sh;
  logic             busy, wel, block, prot_ok, accept;
  logic [7:0]       op_q, out_sh, status;
  logic             out_en;
  logic [ADDR_W-1:0] addr_q, base_mask;
  logic [TM_W-1:0]  rcv_cnt, dur;
  logic [1:0]       lk_pair;
  er_kind_t         kind;

  assign block  = !rst_pin_n || (rcv_cnt != '0);
  assign status = {6'b000000, wel, busy};
  assign kind   = kind_of(op_q);

  fl_serial_rx #(.CNT_W(6), .SH_W(SH_W)) u_rx (
    .clk(clk), .rst(rst), .block(block), .sck(sck), .cs_n(cs_n), .si(si),
    .act(rx_act), .cnt(rx_cnt), .sh(rx_sh), .bit_stb(rx_bit),
    .fall_stb(rx_fall), .end_stb(rx_end), .start_stb(rx_start)
  );

  fl_region_guard #(.ADDR_W(ADDR_W)) u_guard (
    .sub_idx(addr_q[ADDR_W-1:12]), .kind(kind), .sect_lock(sect_lock),
    .sub_hwp(sub_hwp), .ok(prot_ok)
  );

  assign lk_pair = sect_lock[{rx_sh[ADDR_W-1:16], 1'b0} +: 2];

  generate
    if (ADDR_W < SH_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^rx_sh[SH_W-1:ADDR_W];
    end
  endgenerate

  always_comb begin
    case (kind)
      ER_PAGE: begin dur = TM_W'(T_PE);  base_mask = {ADDR_W{1'b1}} << 8;  end
      ER_SUB:  begin dur = TM_W'(T_SSE); base_mask = {ADDR_W{1'b1}} << 12; end
      ER_SECT: begin dur = TM_W'(T_SE);  base_mask = {ADDR_W{1'b1}} << 16; end
      default: begin dur = TM_W'(1);     base_mask = '0;                   end
    endcase
  end

  assign accept = rx_end && (rx_cnt == 6'd32) && (kind != ER_NONE) &&
                  wel && !busy && prot_ok && rst_pin_n;

  fl_erase_timer #(.TM_W(TM_W)) u_tmr (
    .clk(clk), .rst(rst), .abort(!rst_pin_n), .start(accept), .dur(dur),
    .busy(busy), .done(erase_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rcv_cnt    <= '0;
      wel        <= 1'b0;
      op_q       <= 8'h00;
      addr_q     <= '0;
      out_sh     <= 8'h00;
      out_en     <= 1'b0;
      so         <= 1'b0;
      erase_base <= '0;
      erase_size <= 2'd0;
    end else begin
      if (!rst_pin_n)           rcv_cnt <= TM_W'(T_RCV);
      else if (rcv_cnt != '0)   rcv_cnt <= rcv_cnt - TM_W'(1);

      if (rx_start) begin
        op_q   <= 8'h00;
        out_en <= 1'b0;
      end

      if (rx_bit && rx_cnt == 6'd8) begin
        op_q <= rx_sh[7:0];
        if (rx_sh[7:0] == OP_WREN && !busy) wel <= 1'b1;
        if (rx_sh[7:0] == OP_RDSR) begin
          out_sh <= status;
          out_en <= 1'b1;
        end
      end

      if (rx_bit && rx_cnt == 6'd32) begin
        addr_q <= rx_sh[ADDR_W-1:0];
        if (op_q == OP_RDLK && !busy) begin
          out_sh <= {6'b000000, lk_pair};
          out_en <= 1'b1;
        end
      end

      if (rx_fall && out_en) begin
        so     <= out_sh[7];
        out_sh <= {out_sh[6:0], out_sh[7]};
      end

      if (!rx_act) begin
        so     <= 1'b0;
        out_en <= 1'b0;
      end

      if (accept) begin
        wel        <= 1'b0;
        erase_base <= addr_q & base_mask;
        erase_size <= kind;
      end

      if (!rst_pin_n) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/fl_erase_engine_chk.sv
module fl_erase_engine_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_pin_n,
  input logic              cs_n,
  input logic              busy,
  input logic              wel,
  input logic              erase_stb,
  input logic [ADDR_W-1:0] erase_base,
  input logic [1:0]        erase_size
);
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)); // R3
  AST_START_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_n, 2)); // R2
  AST_WEL_DROPS_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel); // R5
  AST_STB_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> !busy && $past(busy)); // R4
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> erase_size != 2'd3); // R4
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    erase_stb && erase_size == 2'd0 |-> erase_base[7:0] == 8'h00); // R8
  AST_SECT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    erase_stb && erase_size == 2'd2 |-> erase_base[15:0] == 16'h0000); // R8
  AST_BUSY_ENDS_CLEANLY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> erase_stb || !$past(rst_pin_n)); // R6
  AST_PIN_ABORTS: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_n |=> !busy && !erase_stb && !wel); // R10
endmodule

bind fl_erase_engine fl_erase_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .cs_n(cs_n), .busy(busy),
  .wel(wel), .erase_stb(erase_stb), .erase_base(erase_base),
  .erase_size(erase_size)
);

// File: tb/tb_fl_erase_engine.sv
module tb_fl_erase_engine;
  localparam int AW   = 18;
  localparam int TPE  = 300;
  localparam int TSSE = 450;
  localparam int TSE  = 900;
  localparam int TRCV = 200;
  localparam int WD   = 150000;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, si = 1'b0, rst_pin_n = 1'b1;
  logic so, erase_stb;
  logic [7:0] sect_lock = '0;
  logic [63:0] sub_hwp = '0;
  logic [AW-1:0] erase_base;
  logic [1:0] erase_size;

  int n_chk = 0, n_fail = 0, cyc_now = 0, t_cs = 0;
  int stb_cnt = 0, stb_time = 0;
  logic [AW-1:0] stb_base = '0;
  logic [1:0] stb_size = '0;

  fl_erase_engine #(.ADDR_W(AW), .TM_W(12), .T_PE(TPE), .T_SSE(TSSE),
                    .T_SE(TSE), .T_RCV(TRCV)) dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
    .rst_pin_n(rst_pin_n), .sect_lock(sect_lock), .sub_hwp(sub_hwp),
    .erase_stb(erase_stb), .erase_base(erase_base), .erase_size(erase_size)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc_now <= cyc_now + 1;

  always @(negedge clk) begin
    if (erase_stb) begin
      stb_cnt  = stb_cnt + 1;
      stb_time = cyc_now;
      stb_base = erase_base;
      stb_size = erase_size;
    end
  end

  always @(posedge clk) begin
    if (cyc_now == WD) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog (R1..): actual cycle %0d expected finish before %0d", cyc_now, WD);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    idle(2);
  endtask

  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1; sck = 1'b0; t_cs = cyc_now;
    idle(3);
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); sck = 1'b0; si = b;
    idle(3);
    @(negedge clk); sck = 1'b1;
    idle(3);
  endtask

  task automatic send_frame(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) put_bit((i < 32) ? w[31-i] : 1'b0);
  endtask

  task automatic read_byte(output logic [7:0] r);
    r = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck = 1'b0;
      idle(3);
      r = {r[6:0], so};
      @(negedge clk); sck = 1'b1;
      idle(3);
    end
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] s2;
    cs_low(); send_frame({8'h05, 24'h0}, 8); read_byte(s); read_byte(s2); cs_high();
    chk(s2 == s, "R1 status repeats", s2, s);
  endtask

  task automatic wren();
    cs_low(); send_frame({8'h06, 24'h0}, 8); cs_high();
  endtask

  task automatic rd_lock(input logic [23:0] a, output logic [7:0] v);
    logic [7:0] v2;
    cs_low(); send_frame({8'hE8, a}, 32); read_byte(v); read_byte(v2); cs_high();
    chk(v2 == v, "R9 lock byte repeats", v2, v);
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a, input int nbits);
    cs_low(); send_frame({op, a}, nbits); cs_high();
  endtask

  function automatic logic [AW-1:0] mask_of(input int k);
    case (k)
      0: return 18'h3FF00;
      1: return 18'h3F000;
      default: return 18'h30000;
    endcase
  endfunction

  initial begin
    logic [7:0] s, v;
    logic [7:0] ops [3];
    int durs [3];
    int c0, t0;
    ops[0] = 8'hDB; ops[1] = 8'h20; ops[2] = 8'hD8;
    durs[0] = TPE; durs[1] = TSSE; durs[2] = TSE;

    idle(5);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R12 reset state
    chk(so == 1'b0 && erase_stb == 1'b0, "R12 outputs after reset", {so, erase_stb}, 0);
    rd_status(s);
    chk(s == 8'h00, "R12 status after reset", s, 8'h00);

    // R1 write enable and status readout
    wren(); rd_status(s);
    chk(s == 8'h02, "R1 WEL set by 0x06", s, 8'h02);

    // R11 unknown code
    cs_low(); send_frame({8'h9F, 24'h0}, 8); read_byte(v); cs_high();
    chk(v == 8'h00, "R11 so silent for unknown code", v, 0);
    rd_status(s);
    chk(s == 8'h02, "R11 state unchanged", s, 8'h02);

    // R2 deselect at wrong bit counts
    foreach (durs[j]) begin end
    for (int q = 0; q < 5; q++) begin
      int nb;
      nb = (q == 0) ? 8 : (q == 1) ? 24 : (q == 2) ? 31 : (q == 3) ? 33 : 40;
      wren(); c0 = stb_cnt;
      erase(8'hD8, 24'h010000, nb);
      idle(40); rd_status(s);
      chk(stb_cnt == c0, "R2 no erase on misaligned deselect", stb_cnt - c0, 0);
      chk(s == 8'h02, "R2 WEL kept after discarded erase", s, 8'h02);
    end

    // R4 R5 R8 sweep of kinds over sectors, upper bits don't care
    for (int k = 0; k < 3; k++) begin
      for (int sc = 0; sc < 4; sc++) begin
        logic [15:0] off;
        logic [23:0] a;
        logic [AW-1:0] expb;
        off = 16'(k * 16'h3C5B + sc * 16'h1F37);
        a = {6'b101101, 2'(sc), off};
        expb = {2'(sc), off} & mask_of(k);
        wren(); c0 = stb_cnt;
        erase(ops[k], a, 32); t0 = t_cs;
        idle(durs[k] + 20);
        chk(stb_cnt == c0 + 1, "R4 exactly one strobe", stb_cnt - c0, 1);
        chk(stb_time - t0 == durs[k] + 2, "R4 cycle duration", stb_time - t0, durs[k] + 2);
        chk(stb_size == 2'(k), "R4 size code", stb_size, k);
        chk(stb_base == expb, "R8 region base", stb_base, expb);
        rd_status(s);
        chk(s == 8'h00, "R5 WEL and WIP clear after erase", s, 8'h00);
      end
    end

    // R3 erase without WEL
    c0 = stb_cnt;
    erase(8'hDB, 24'h000400, 32);
    idle(TPE + 20); rd_status(s);
    chk(stb_cnt == c0 && s == 8'h00, "R3 erase needs WEL", stb_cnt - c0, 0);

    // R9 lock byte sweep
    for (int sc = 0; sc < 4; sc++) begin
      for (int lv = 0; lv < 4; lv++) begin
        sect_lock = 8'(lv << (2 * sc));
        rd_lock({6'b0, 2'(sc), 16'h5A5A}, v);
        chk(v == 8'(lv), "R9 lock byte of sector", v, lv);
      end
    end

    // R6 commands during a running cycle
    sect_lock = 8'b1000_0000;
    wren(); c0 = stb_cnt;
    erase(8'hD8, 24'h03ABCD, 32); t0 = t_cs;
    rd_status(s);
    chk(s == 8'h01, "R5 WIP set WEL clear while busy", s, 8'h01);
    wren();
    rd_lock(24'h030000, v);
    chk(v == 8'h00, "R6 lock read ignored while busy", v, 0);
    idle(TSE);
    chk(stb_cnt == c0 + 1, "R6 single strobe", stb_cnt - c0, 1);
    chk(stb_time - t0 == TSE + 2, "R6 duration unaffected", stb_time - t0, TSE + 2);
    chk(stb_base == 18'h30000, "R6 region unaffected", stb_base, 18'h30000);
    rd_status(s);
    chk(s == 8'h00, "R6 write enable ignored while busy", s, 8'h00);
    rd_lock(24'h030000, v);
    chk(v == 8'h02, "R9 lock-down bit read", v, 8'h02);

    // R7 protection
    sect_lock = 8'b0001_0000;
    sub_hwp = '0; sub_hwp[21] = 1'b1;
    for (int p = 0; p < 7; p++) begin
      logic [7:0] op;
      logic [23:0] a;
      bit okx;
      case (p)
        0: begin op = 8'hDB; a = 24'h015300; okx = 0; end
        1: begin op = 8'h20; a = 24'h015000; okx = 0; end
        2: begin op = 8'hDB; a = 24'h016100; okx = 1; end
        3: begin op = 8'hD8; a = 24'h01FFFF; okx = 0; end
        4: begin op = 8'hD8; a = 24'h020000; okx = 0; end
        5: begin op = 8'hDB; a = 24'h02F000; okx = 0; end
        default: begin op = 8'hD8; a = 24'h030000; okx = 1; end
      endcase
      wren(); c0 = stb_cnt;
      erase(op, a, 32);
      idle(TSE + 20); rd_status(s);
      chk(stb_cnt == c0 + int'(okx), "R7 protection outcome", stb_cnt - c0, int'(okx));
      chk(s == (okx ? 8'h00 : 8'h02), "R7 WEL after protected attempt", s, okx ? 0 : 2);
    end
    sect_lock = '0; sub_hwp = '0;

    // R10 reset pin abort and lockout
    wren(); c0 = stb_cnt;
    erase(8'hD8, 24'h000000, 32);
    idle(100);
    @(negedge clk); rst_pin_n = 1'b0;
    idle(3);
    @(negedge clk); rst_pin_n = 1'b1;
    wren();
    idle(TSE + 50);
    chk(stb_cnt == c0, "R10 aborted erase gives no strobe", stb_cnt - c0, 0);
    rd_status(s);
    chk(s == 8'h00, "R10 cleared and lockout ignores command", s, 8'h00);
    wren(); rd_status(s);
    chk(s == 8'h02, "R10 selectable after recovery", s, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule